// File: doc/BRIEF.md
# Serial Shift Clock Unit

A programmable serial shifter for general use. It holds an 8-bit data shifter, a 4-bit transfer counter and a clock selector that picks a clock for each of the two. Software controls it through a small register port. Each unit can be clocked by a software strobe, by a timer match pulse, or by edges of an external serial clock. Software can also drive the serial clock line itself, which lets it run a transfer as master.

The external clock and data pins are synchronized with two flops. Edges are turned into single-cycle pulses in the system clock domain. The most significant bit of the shifter drives the serial data output. New bits enter at the least significant bit. When the counter wraps it sets a sticky overflow flag, so software can tell when a transfer of 16 counter steps (8 bits in the both-edge external mode) has finished.

Top module: `serial_shift_clock_unit`

## Requirements
- R1: After reset the data, control, counter and flag registers read 0, and `sd_out`, `sck_out` and `ovf` are 0.
- R2: With the clock source field (control address 1, bits [1:0]) equal to 00, neither the shifter nor the counter moves unless a strobe is written. Timer pulses and external clock edges have no effect.
- R3: A control write with bits [1:0] = 00 and bit 2 = 1 shifts the data register one place toward the MSB and adds 1 to the counter, at the clock edge of that write. The new LSB is the synchronized data input.
- R4: `sd_out` always equals bit 7 of the data register (address 0).
- R5: With source 01, every cycle with `tmr_match` high shifts the data register once and adds 1 to the counter.
- R6: With source 10 the data register shifts on each rising edge of the synchronized `sck_in`. With source 11 it shifts on each falling edge.
- R7: With source 10 or 11 and the held select (control bit 2) at 0, the counter adds 1 on both edges of `sck_in`.
- R8: With source 10 or 11 and the held select at 1, the counter ignores `sck_in`. It adds 1 only on control writes with bit 3 = 1. The data register still shifts on the selected edge.
- R9: A control write with bit 3 = 1 inverts the clock output latch, whatever the direction bit (control bit 4) is set to. `sck_oe` follows the direction bit, and `sck_out` equals the latch when the direction bit is 1 and 0 otherwise.
- R10: Control bits 2 and 3 always read back as 0. Bits [1:0] and 4 read back as written.
- R11: A counter step from 15 to 0 sets `ovf` (read at address 3, bit 0). A write of bit 0 = 1 to address 3 clears it. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R12: Writes to the data register (address 0) and to the counter (address 2, bits [3:0]) take priority over a shift or count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 data, 1 control, 2 counter, 3 flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sd_in | input | 1 | Serial data input pin |
| sd_out | output | 1 | Serial data output |
| sck_in | input | 1 | External serial clock input |
| sck_out | output | 1 | Serial clock output value |
| sck_oe | output | 1 | Serial clock output enable |
| tmr_match | input | 1 | Timer compare-match pulse |
| ovf | output | 1 | Sticky counter overflow flag |

## Verification
Two functions can fall in the same cycle: a counter wrap that sets the overflow flag, and a software clear of that flag. The bench provokes this by loading the counter with 15, selecting the timer source, and raising `tmr_match` in the same cycle as the clear write. It judges the result by the flag being set afterwards. The same method checks a register write against a shift or count in the same cycle. The bench pairs a timer pulse with a data write and with a counter write, and expects the written values to stand while the unaffected unit still advances.

// File: rtl/serial_shift_clock_unit.sv
module serial_shift_clock_unit #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sd_in,
  output logic       sd_out,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       tmr_match,
  output logic       ovf
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [1:0]    sd_sy, sck_sy;
  logic          sck_d;
  logic [DW-1:0] sr;
  logic [CW-1:0] cnt;
  logic [1:0]    src_q;
  logic          hold_q, dir_q, sck_lat, flag;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sd_sy <= '0; sck_sy <= '0; sck_d <= 1'b0;
    end else begin
      sd_sy  <= {sd_sy[0], sd_in};
      sck_sy <= {sck_sy[0], sck_in};
      sck_d  <= sck_sy[1];
    end

  wire rise   = sck_sy[1] & ~sck_d;
  wire fall   = ~sck_sy[1] & sck_d;
  wire wr_dat = reg_wr && reg_addr == 2'd0;
  wire wr_ctl = reg_wr && reg_addr == 2'd1;
  wire wr_cnt = reg_wr && reg_addr == 2'd2;
  wire wr_clr = reg_wr && reg_addr == 2'd3 && reg_wdata[0];
  wire sw_stb = wr_ctl && reg_wdata[1:0] == 2'b00 && reg_wdata[2];
  wire tog    = wr_ctl && reg_wdata[3];
  wire ext    = src_q[1];

  wire shift_en = sw_stb | (src_q == 2'b01 & tmr_match)
                | (src_q == 2'b10 & rise) | (src_q == 2'b11 & fall);
  wire cnt_en   = sw_stb | (src_q == 2'b01 & tmr_match)
                | (ext & ~hold_q & (rise | fall)) | (ext & hold_q & tog);
  wire wrap     = cnt_en & ~wr_cnt & (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr <= '0; cnt <= '0; flag <= 1'b0;
      src_q <= 2'b00; hold_q <= 1'b0; dir_q <= 1'b0; sck_lat <= 1'b0;
    end else begin
      if (wr_dat)        sr <= reg_wdata[DW-1:0];
      else if (shift_en) sr <= {sr[DW-2:0], sd_sy[1]};
      if (wr_cnt)        cnt <= reg_wdata[CW-1:0];
      else if (cnt_en)   cnt <= cnt + 1'b1;
      if (wrap)          flag <= 1'b1;
      else if (wr_clr)   flag <= 1'b0;
      if (wr_ctl) begin
        src_q  <= reg_wdata[1:0];
        hold_q <= reg_wdata[2];
        dir_q  <= reg_wdata[4];
      end
      if (tog) sck_lat <= ~sck_lat;
    end

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = 8'(sr);
      2'd1:    reg_rdata = {3'b000, dir_q, 2'b00, src_q};
      2'd2:    reg_rdata = 8'(cnt);
      default: reg_rdata = {7'd0, flag};
    endcase

  assign sd_out  = sr[DW-1];
  assign sck_oe  = dir_q;
  assign sck_out = dir_q & sck_lat;
  assign ovf     = flag;

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == 2'b00 && !reg_wr) |=> ($stable(sr) && $stable(cnt)));
  a_r7_both_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (ext && !hold_q && (rise || fall) && !wr_cnt) |=> ((cnt - $past(cnt)) == CW'(1)));
  a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    tog |=> (sck_lat != $past(sck_lat)));
  a_r11_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wr_clr) |=> ovf);
endmodule

// File: tb/test_serial_shift_clock_unit.sv
module test_serial_shift_clock_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic sd_in = 1'b0, sck_in = 1'b0, tmr_match = 1'b0;
  logic sd_out, sck_out, sck_oe, ovf;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_shift_clock_unit i_serial_shift_clock_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_in(sd_in),
    .sd_out(sd_out), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .tmr_match(tmr_match), .ovf(ovf));

  // {sd_in bit, expected data register after the strobe}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'h01}, {1'b0, 8'h02}, {1'b1, 8'h05}, {1'b1, 8'h0B},
    {1'b0, 8'h16}, {1'b0, 8'h2C}, {1'b1, 8'h59}, {1'b0, 8'hB2}};

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck(input logic v);
    @(negedge clk); sck_in = v; idle(5);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg", v, 0);
    end
    chk("R1 sd_out", sd_out, 0); chk("R1 sck_out", sck_out, 0); chk("R1 ovf", ovf, 0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sd_in = VEC[i][8]; idle(3);
      wr(2'd1, 8'h04);
      rd(2'd0, v); chk("R3 shift", v, VEC[i][7:0]);
      rd(2'd2, v); chk("R3 count", v, i + 1);
      chk("R4 sd_out", sd_out, VEC[i][7]);
    end
    rd(2'd1, v); chk("R10 strobe reads 0", v, 8'h00);

    @(negedge clk); tmr_match = 1'b1; @(negedge clk); tmr_match = 1'b0;
    sck(1'b1); sck(1'b0);
    wr(2'd1, 8'h00);
    rd(2'd0, v); chk("R2 no shift", v, 8'hB2);
    rd(2'd2, v); chk("R2 no count", v, 8);

    sd_in = 1'b1; idle(3);
    wr(2'd1, 8'h01);
    @(negedge clk); tmr_match = 1'b1; idle(3); tmr_match = 1'b0;
    rd(2'd0, v); chk("R5 timer shift", v, 8'h97);
    rd(2'd2, v); chk("R5 timer count", v, 11);

    wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h02);
    sck(1'b1);
    rd(2'd0, v); chk("R6 rise shift", v, 8'h01);
    rd(2'd2, v); chk("R7 rise count", v, 1);
    sck(1'b0);
    rd(2'd0, v); chk("R6 fall no shift", v, 8'h01);
    rd(2'd2, v); chk("R7 fall count", v, 2);
    wr(2'd1, 8'h03);
    sck(1'b1);
    rd(2'd0, v); chk("R6 neg mode rise", v, 8'h01);
    sck(1'b0);
    rd(2'd0, v); chk("R6 neg mode fall", v, 8'h03);
    rd(2'd2, v); chk("R7 count both", v, 4);

    wr(2'd1, 8'h07);
    sck(1'b1); sck(1'b0);
    rd(2'd0, v); chk("R8 shift still on edge", v, 8'h07);
    rd(2'd2, v); chk("R8 edges not counted", v, 4);
    wr(2'd1, 8'h0F);
    rd(2'd2, v); chk("R8 toggle counts", v, 5);
    chk("R9 hidden while input", sck_out, 0);

    wr(2'd1, 8'h13);
    chk("R9 latch toggled while input", sck_out, 1);
    chk("R9 oe", sck_oe, 1);
    wr(2'd1, 8'h1B);
    chk("R9 toggle back", sck_out, 0);
    rd(2'd1, v); chk("R10 readback", v, 8'h13);

    wr(2'd2, 8'h0F); wr(2'd1, 8'h01);
    @(negedge clk); tmr_match = 1'b1; @(negedge clk); tmr_match = 1'b0;
    chk("R11 wrap sets", ovf, 1);
    rd(2'd2, v); chk("R11 wrapped to 0", v, 0);
    rd(2'd3, v); chk("R11 flag read", v, 1);
    wr(2'd3, 8'h01);
    chk("R11 clear", ovf, 0);
    wr(2'd2, 8'h0F);
    @(negedge clk); tmr_match = 1'b1; reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h01;
    @(negedge clk); tmr_match = 1'b0; reg_wr = 1'b0;
    chk("R11 set wins over clear", ovf, 1);
    wr(2'd3, 8'h01);
    chk("R11 clear again", ovf, 0);

    @(negedge clk); tmr_match = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h5A;
    @(negedge clk); tmr_match = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); chk("R12 data write wins", v, 8'h5A);
    rd(2'd2, v); chk("R12 count still steps", v, 1);
    @(negedge clk); tmr_match = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h07;
    @(negedge clk); tmr_match = 1'b0; reg_wr = 1'b0;
    rd(2'd2, v); chk("R12 count write wins", v, 7);
    rd(2'd0, v); chk("R12 shift still steps", v, 8'hB5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule